// File: doc/BRIEF.md
# Packed Eight-Slot TDM Audio Frame Engine

This block shifts eight audio channels per frame over a single pair of serial data lines, one line out and one line in, using time-division multiplexing. The block is clocked directly by the serial bit clock. A frame holds eight equal slots. In the long frame a slot is 32 bit clocks, and in the short frame a slot is 16 bit clocks. A left/right framing clock marks the frame. It is low for the first four slots, which carry the left channels, and high for the last four, which carry the right channels.

On the internal side, eight parallel transmit words are captured once per frame and serialized onto the output line. The eight words received on the input line are published together with a one-cycle strobe when the frame is complete. As clock master, the block generates the framing clock itself. As clock slave, it follows an external framing clock and restarts its frame whenever that clock falls. Samples are signed two's complement words that the block carries unchanged, left-aligned in their slots.

Top module: `tdm_pack_port`

## Requirements
- R1: While `rst` is high, `rx_valid`, `lr_out`, `sdo` and `rx_data` are all 0. The first frame after reset in master mode transmits zeros in every slot.
- R2: With `mode_256`=1 a frame is 256 bit clocks made of 8 slots of 32. With `mode_256`=0 a frame is 128 bit clocks made of 8 slots of 16. Slot k (k=0..7) occupies bit positions k*slot_len to k*slot_len+slot_len-1 of the frame.
- R3: In master mode (`master`=1), `lr_out` is 0 during frame positions below half the frame length (slots 0..3, left) and 1 for the rest (slots 4..7, right). The first frame starts at the first rising edge after reset is released, and `lr_in` has no effect.
- R4: Slot k of `sdo` carries transmit word k, `tx_data[k*SAMPLE_W +: SAMPLE_W]`, most significant bit first. It starts at the first bit clock of the slot, and `sdo` changes only after a rising edge.
- R5: In a slot, `sdo` is 0 at every bit position at or beyond `SAMPLE_W`. When `SAMPLE_W` exceeds the slot length, only the top slot_len bits of the word are sent.
- R6: `sdi` is sampled on the falling bit clock edge. The bits of slot k fill channel k of `rx_data` from its most significant bit down. Input bits beyond `SAMPLE_W` in a slot are ignored, and word bits that the slot cannot hold read as 0.
- R7: One cycle after the last bit of a complete frame, `rx_valid` is high for exactly one cycle and `rx_data` holds that frame's eight words. `rx_data` then stays unchanged until the next strobe.
- R8: Transmit words are captured at the rising edge that starts a frame. Changes to `tx_data` during a frame do not alter that frame's `sdo` bits.
- R9: In slave mode (`master`=0), `lr_out` stays 0. Frame position 0 begins at the rising edge that samples `lr_in` low after it was sampled high. A fall that arrives before the frame is complete truncates that frame without an `rx_valid` strobe.
- R10: Two's complement values are carried bit-exact in both directions, including positive full scale 0x7FFFFF, zero 0x000000 and negative full scale 0x800000 (24-bit words).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all state advances on its rising edge except the input sampler |
| rst | input | 1 | Synchronous active-high reset |
| mode_256 | input | 1 | 1 selects 256-clock frames (32-bit slots), 0 selects 128-clock frames (16-bit slots) |
| master | input | 1 | 1 generates the framing clock, 0 follows `lr_in` |
| lr_in | input | 1 | External framing clock used in slave mode |
| lr_out | output | 1 | Generated framing clock in master mode, 0 in slave mode |
| sdi | input | 1 | Serial input carrying eight playback channels |
| sdo | output | 1 | Serial output carrying eight capture channels |
| tx_data | input | 8*SAMPLE_W | Eight transmit words, slot k in bits k*SAMPLE_W upward |
| rx_data | output | 8*SAMPLE_W | Eight received words, slot k in bits k*SAMPLE_W upward |
| rx_valid | output | 1 | One-cycle strobe when `rx_data` is refreshed |

## Verification
The frame boundary edge does two jobs at once. It publishes the received words with `rx_valid`, and it captures the next transmit set. In slave mode the same edge can also be a framing clock fall. The bench changes `tx_data` a third of the way into each frame and expects the new words one frame later. In the same cycle it expects the received words of the finished frame on the scoreboard. A mid-frame framing clock fall checks the third case: the counters restart, no strobe appears, and the transmit words are captured again at the new start.

// File: rtl/tdm_pack_pkg.sv
`timescale 1ns/100ps
// Shared constants, types and small helpers for the packed TDM frame engine.
package tdm_pack_pkg;

    // Eight slots per frame: four left then four right.
    localparam int SLOTS      = 8;
    localparam int POS_W      = 8;   // covers up to 256 bit positions
    localparam int SLOT_IDX_W = 3;
    localparam int BIT_IDX_W  = 5;

    typedef logic [POS_W-1:0] frame_pos_t;

    typedef enum logic {
        FRAME_128 = 1'b0,
        FRAME_256 = 1'b1
    } frame_len_e;

    typedef struct packed {
        logic [SLOT_IDX_W-1:0] slot;
        logic [BIT_IDX_W-1:0]  bit_idx;
    } slot_loc_t;

    // Bit clocks per slot.
    function automatic logic [5:0] slot_bits(frame_len_e f);
        return (f == FRAME_256) ? 6'd32 : 6'd16;
    endfunction

    // Last bit position of the frame.
    function automatic frame_pos_t frame_last(frame_len_e f);
        return (f == FRAME_256) ? 8'd255 : 8'd127;
    endfunction

    // First bit position of the right half.
    function automatic frame_pos_t half_point(frame_len_e f);
        return (f == FRAME_256) ? 8'd128 : 8'd64;
    endfunction

    // Split a frame position into slot number and bit within the slot.
    function automatic slot_loc_t locate(frame_pos_t pos, frame_len_e f);
        slot_loc_t l;
        if (f == FRAME_256) begin
            l.slot    = pos[7:5];
            l.bit_idx = pos[4:0];
        end else begin
            l.slot    = pos[6:4];
            l.bit_idx = {1'b0, pos[3:0]};
        end
        return l;
    endfunction

    // Number of word bits that fit in a slot.
    function automatic logic [5:0] used_bits(frame_len_e f, int w);
        if (w < int'(slot_bits(f)))
            return 6'(w);
        else
            return slot_bits(f);
    endfunction

endpackage

// File: rtl/tdm_frame_timer.sv
// Frame position counter, framing clock generator and slave realignment.
module tdm_frame_timer
    import tdm_pack_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  frame_len_e flen,
    input  logic       master,
    input  logic       lr_in,
    output frame_pos_t pos,
    output logic       at_last,
    output logic       frame_load,
    output logic       lr_gen
);

    logic       lr_q;
    logic       lr_fall;
    frame_pos_t pos_next;

    // Previous framing clock sample, no reset needed: it only feeds the
    // fall detector, which is gated by reset through the counter.
    always_ff @(posedge clk) begin
        lr_q <= lr_in;
    end

    assign at_last = (pos == frame_last(flen));
    assign lr_fall = !master && lr_q && !lr_in;

    // A new frame starts after the last position or on a slave fall.
    assign frame_load = at_last || lr_fall;

    always_comb begin
        if (frame_load)
            pos_next = '0;
        else
            pos_next = pos + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pos <= '0;
        else
            pos <= pos_next;
    end

    // Left half low, right half high; silent in slave mode.
    assign lr_gen = master && (pos >= half_point(flen));

endmodule

// File: rtl/tdm_tx_serializer.sv
// Holds the eight transmit words for one frame and selects the output bit.
module tdm_tx_serializer
    import tdm_pack_pkg::*;
#(
    parameter int W = 24
) (
    input  logic                      clk,
    input  logic                      rst,
    input  frame_len_e                flen,
    input  frame_pos_t                pos,
    input  logic                      load,
    input  logic [SLOTS-1:0][W-1:0]   tx_words,
    output logic                      sdo
);

    localparam int IW = (W > 1) ? $clog2(W) : 1;

    logic [SLOTS-1:0][W-1:0] hold;
    slot_loc_t               loc;
    logic [5:0]              used;
    logic [IW-1:0]           idx;

    // Capture at the edge that enters frame position 0.
    always_ff @(posedge clk) begin
        if (rst)
            hold <= '0;
        else if (load)
            hold <= tx_words;
    end

    // Output bit is a function of registered state only, so it moves
    // right after the rising edge.
    always_comb begin
        loc  = locate(pos, flen);
        used = used_bits(flen, W);
        idx  = IW'(W - 1 - int'(loc.bit_idx));
        sdo  = 1'b0;
        if ({1'b0, loc.bit_idx} < used)
            sdo = hold[loc.slot][idx];
    end

endmodule

// File: rtl/tdm_rx_deserializer.sv
// Samples the input line on the falling edge and assembles eight words.
module tdm_rx_deserializer
    import tdm_pack_pkg::*;
#(
    parameter int W = 24
) (
    input  logic                      clk,
    input  logic                      rst,
    input  frame_len_e                flen,
    input  frame_pos_t                pos,
    input  logic                      at_last,
    input  logic                      sdi,
    output logic [SLOTS-1:0][W-1:0]   rx_words,
    output logic                      rx_valid
);

    localparam int IW = (W > 1) ? $clog2(W) : 1;

    logic                    sdi_s;
    logic [SLOTS-1:0][W-1:0] acc;
    logic [SLOTS-1:0][W-1:0] acc_next;
    slot_loc_t               loc;
    logic [5:0]              used;
    logic [IW-1:0]           idx;

    // Mid-bit sample of the input line.
    always_ff @(negedge clk) begin
        if (rst)
            sdi_s <= 1'b0;
        else
            sdi_s <= sdi;
    end

    // Each slot is cleared at its first bit so unfilled bits read zero.
    always_comb begin
        loc      = locate(pos, flen);
        used     = used_bits(flen, W);
        idx      = IW'(W - 1 - int'(loc.bit_idx));
        acc_next = acc;
        if (loc.bit_idx == '0)
            acc_next[loc.slot] = '0;
        if ({1'b0, loc.bit_idx} < used)
            acc_next[loc.slot][idx] = sdi_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc      <= '0;
            rx_words <= '0;
            rx_valid <= 1'b0;
        end else begin
            acc      <= acc_next;
            rx_valid <= at_last;
            if (at_last)
                rx_words <= acc_next;
        end
    end

endmodule

// File: rtl/tdm_pack_port.sv
// Eight-slot packed TDM serial port, top level.
module tdm_pack_port
    import tdm_pack_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         mode_256,
    input  logic                         master,
    input  logic                         lr_in,
    output logic                         lr_out,
    input  logic                         sdi,
    output logic                         sdo,
    input  logic [SLOTS*SAMPLE_W-1:0]    tx_data,
    output logic [SLOTS*SAMPLE_W-1:0]    rx_data,
    output logic                         rx_valid
);

    frame_len_e                     flen;
    frame_pos_t                     frame_pos;
    logic                           at_last;
    logic                           frame_load;
    logic                           lr_gen;
    logic [SLOTS-1:0][SAMPLE_W-1:0] tx_words;
    logic [SLOTS-1:0][SAMPLE_W-1:0] rx_words;

    assign flen = frame_len_e'(mode_256);

    // Channel k sits at bits k*SAMPLE_W upward on both parallel buses.
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        assign tx_words[k]                        = tx_data[k*SAMPLE_W +: SAMPLE_W];
        assign rx_data[k*SAMPLE_W +: SAMPLE_W]    = rx_words[k];
    end

    tdm_frame_timer timer_i (
        .clk        (clk),
        .rst        (rst),
        .flen       (flen),
        .master     (master),
        .lr_in      (lr_in),
        .pos        (frame_pos),
        .at_last    (at_last),
        .frame_load (frame_load),
        .lr_gen     (lr_gen)
    );

    tdm_tx_serializer #(.W(SAMPLE_W)) tx_i (
        .clk      (clk),
        .rst      (rst),
        .flen     (flen),
        .pos      (frame_pos),
        .load     (frame_load),
        .tx_words (tx_words),
        .sdo      (sdo)
    );

    tdm_rx_deserializer #(.W(SAMPLE_W)) rx_i (
        .clk      (clk),
        .rst      (rst),
        .flen     (flen),
        .pos      (frame_pos),
        .at_last  (at_last),
        .sdi      (sdi),
        .rx_words (rx_words),
        .rx_valid (rx_valid)
    );

    assign lr_out = lr_gen;

endmodule

// File: rtl/tdm_pack_port_chk.sv
// Temporal checks on the TDM frame engine, attached by bind.
module tdm_pack_port_chk
    import tdm_pack_pkg::*;
#(
    parameter int W = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_256,
    input  logic       master,
    input  logic       lr_in,
    input  logic       lr_out,
    input  logic       sdo,
    input  logic       rx_valid,
    input  frame_pos_t frame_pos
);

    frame_len_e flen;
    frame_pos_t ref_cnt;
    logic [5:0] bit_in_slot;

    assign flen        = frame_len_e'(mode_256);
    assign bit_in_slot = mode_256 ? {1'b0, frame_pos[4:0]} : {2'b00, frame_pos[3:0]};

    // Independent frame-length model for the master framing clock.
    always_ff @(posedge clk) begin
        if (rst)
            ref_cnt <= '0;
        else if (ref_cnt == frame_last(flen))
            ref_cnt <= '0;
        else
            ref_cnt <= ref_cnt + 1'b1;
    end

    a_r3_lr_level: assert property (@(posedge clk) disable iff (rst)
        master |-> (lr_out == (ref_cnt >= half_point(flen))));

    a_r2_wrap: assert property (@(posedge clk) disable iff (rst)
        (frame_pos == frame_last(flen)) |=> (frame_pos == '0));

    a_r9_slave_lr_quiet: assert property (@(posedge clk) disable iff (rst)
        !master |-> !lr_out);

    a_r9_slave_realign: assert property (@(posedge clk) disable iff (rst)
        (!master && $past(lr_in) && !lr_in) |=> (frame_pos == '0));

    a_r7_valid_single: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);

    a_r7_valid_at_start: assert property (@(posedge clk) disable iff (rst)
        rx_valid |-> (frame_pos == '0));

    a_r5_pad_zero: assert property (@(posedge clk) disable iff (rst)
        (int'(bit_in_slot) >= W) |-> !sdo);

endmodule

bind tdm_pack_port tdm_pack_port_chk #(.W(SAMPLE_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .mode_256  (mode_256),
    .master    (master),
    .lr_in     (lr_in),
    .lr_out    (lr_out),
    .sdo       (sdo),
    .rx_valid  (rx_valid),
    .frame_pos (frame_pos)
);

// File: tb/tdm_pack_port_tb_top.sv
`timescale 1ns/100ps
module tdm_pack_port_tb_top;

    localparam int W  = 24;
    localparam int NS = 8;
    localparam int VW = NS * W;

    typedef logic [VW-1:0] frame_vec_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_256 = 1'b1;
    logic       master = 1'b1;
    logic       lr_in = 1'b0;
    logic       sdi = 1'b0;
    frame_vec_t tx_data = '0;
    logic       lr_out;
    logic       sdo;
    logic       rx_valid;
    frame_vec_t rx_data;

    tdm_pack_port #(.SAMPLE_W(W)) dut_i (
        .clk      (clk),
        .rst      (rst),
        .mode_256 (mode_256),
        .master   (master),
        .lr_in    (lr_in),
        .lr_out   (lr_out),
        .sdi      (sdi),
        .sdo      (sdo),
        .tx_data  (tx_data),
        .rx_data  (rx_data),
        .rx_valid (rx_valid)
    );

    always #2.5 clk = ~clk;

    int         total = 0;
    int         bad   = 0;
    frame_vec_t rx_q[$];
    frame_vec_t last_rx = '0;

    task automatic check(input string tag, input frame_vec_t act, input frame_vec_t exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic frame_vec_t pack8(input logic [W-1:0] a, b, c, d, e, f, g, h);
        return {h, g, f, e, d, c, b, a};
    endfunction

    // Slot bits as seen on the line, left-aligned in 32 bits.
    function automatic logic [31:0] line_slot(input logic [W-1:0] w, input int sl);
        logic [31:0] r = '0;
        for (int b = 0; b < sl; b++)
            if (b < W) r[31-b] = w[W-1-b];
        return r;
    endfunction

    // Word expected in rx_data after a slot of length sl.
    function automatic frame_vec_t rx_expect(input frame_vec_t v, input int sl);
        frame_vec_t r = '0;
        for (int s = 0; s < NS; s++)
            for (int b = 0; b < sl && b < W; b++)
                r[s*W + W-1-b] = v[s*W + W-1-b];
        return r;
    endfunction

    // Scoreboard monitor: compares published words against the queue.
    always @(negedge clk) begin
        if (!rst && rx_valid) begin
            if (rx_q.size() == 0) begin
                check("R7 R9 strobe with no frame pending", 1, 0);
            end else begin
                frame_vec_t e;
                e = rx_q.pop_front();
                last_rx = e;
                check("R6 R10 received words", rx_data, e);
            end
        end
    end

    task automatic do_reset(input logic m256, input logic ms);
        @(posedge clk); #1;
        rst = 1'b1; mode_256 = m256; master = ms;
        lr_in = ms ? 1'b0 : 1'b1; sdi = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset strobe/lr/sdo", {rx_valid, lr_out, sdo}, 0);
        check("R1 reset rx_data", rx_data, 0);
        @(posedge clk); #1;
        rst = 1'b0;
        last_rx = '0;
    endtask

    // Slave lead-in: framing clock high, then falls to start frame 0.
    task automatic preamble(input int k);
        for (int j = 0; j < k; j++) begin
            lr_in = (j < k-1);
            sdi   = 1'b0;
            @(posedge clk); #1;
        end
    endtask

    // One full frame starting in bench position 0, just after a rising edge.
    task automatic run_frame(input frame_vec_t exp_tx, input frame_vec_t next_tx,
                             input frame_vec_t words);
        int          sl = (mode_256 ? 32 : 16);
        int          fl = sl * NS;
        int          half = fl / 2;
        logic [31:0] act [NS];
        bit          lr_bad = 0;
        for (int s = 0; s < NS; s++) act[s] = '0;
        rx_q.push_back(rx_expect(words, sl));
        for (int p = 0; p < fl; p++) begin
            int s = p / sl;
            int b = p % sl;
            if (b < W) sdi = words[s*W + W-1-b];
            else       sdi = 1'b1;          // junk beyond the word: ignored (R6)
            if (master) lr_in = p[1];       // ignored in master mode (R3)
            else        lr_in = (((p+1) % fl) >= half);
            if (p == fl/3) tx_data = next_tx;   // mid-frame change (R8)
            @(negedge clk);
            act[s][31-b] = sdo;
            if (lr_out !== (master ? (p >= half) : 1'b0)) lr_bad = 1;
            @(posedge clk); #1;
        end
        for (int s = 0; s < NS; s++)
            check($sformatf("R4 R5 R8 slot %0d line bits", s), act[s],
                  line_slot(exp_tx[s*W +: W], sl));
        check(master ? "R2 R3 framing clock pattern" : "R9 framing clock quiet", lr_bad, 0);
    endtask

    task automatic drain();
        repeat (8) begin
            sdi = 1'b0;
            @(posedge clk); #1;
        end
        @(negedge clk);
        check("R7 every frame published", rx_q.size(), 0);
        check("R7 rx_data held after strobe", rx_data, last_rx);
    endtask

    frame_vec_t p_fs, p_a, p_b, p_c;

    initial begin
        p_fs = pack8(24'h7FFFFF, 24'h800000, 24'h000000, 24'hFFFFFF,
                     24'h000001, 24'h7FFFFF, 24'h800000, 24'h400000);
        p_a  = pack8(24'h123456, 24'h89ABCD, 24'hF0F0F0, 24'h0F0F0F,
                     24'hA5A5A5, 24'h5A5A5A, 24'hC3C3C3, 24'h3C3C3C);
        p_b  = pack8(24'h800001, 24'h7FFFFE, 24'h00FF00, 24'hFF00FF,
                     24'h13579B, 24'h2468AC, 24'hDEADBE, 24'h0BEEF0);
        p_c  = pack8(24'h111111, 24'h222222, 24'h333333, 24'h444444,
                     24'h555555, 24'h666666, 24'h777777, 24'h888888);
        fork
            begin
                // Master, 256-clock frames; first frame sends zeros (R1).
                tx_data = p_c;
                do_reset(1'b1, 1'b1);
                run_frame('0,   p_fs, p_a);
                run_frame(p_fs, p_a,  p_fs);
                run_frame(p_a,  p_b,  p_b);
                drain();
                // Master, 128-clock frames: words truncated to 16 bits (R2 R5).
                do_reset(1'b0, 1'b1);
                run_frame('0,  p_b, p_fs);
                run_frame(p_b, p_c, p_a);
                drain();
                // Slave, 256-clock frames with a mid-frame slip (R9).
                tx_data = p_c;
                do_reset(1'b1, 1'b0);
                preamble(10);
                run_frame(p_c, p_a,  p_b);
                run_frame(p_a, p_fs, p_c);
                preamble(40);
                run_frame(p_fs, p_b, p_a);
                drain();
                // Slave, 128-clock frames.
                tx_data = p_b;
                do_reset(1'b0, 1'b0);
                preamble(5);
                run_frame(p_b, p_a, p_fs);
                run_frame(p_a, p_c, p_b);
                drain();
            end
            begin
                #(200000 * 5);
                total++;
                bad++;
                $display("FAIL watchdog expired act=running exp=finished");
            end
        join_any
        disable fork;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule